// File: doc/BRIEF.md
# Double-Buffered PWM Compare Register Bank

This block stores the compare thresholds used by a PWM time base. There are four of them, A, B, C and D. Each one has two copies: a shadow copy that software fills at any time, and an active copy that drives the compare outputs. When a register is double-buffered, a new shadow value reaches the active copy only at a chosen counter event. The counter at zero, the counter at its period value, or either of the two can be chosen, and the choice is made per register. This keeps a compare edge from moving partway through a PWM cycle.

Each register can be switched out of double-buffering. Writes to its active address then take effect directly. While double-buffering is on, writes to the active address are dropped, so the only way to change the active value is through the shadow copy. Every selected event transfers a pending value; there is no option to skip events. A shadow copy that has not been written since its last transfer is not transferred again. The counter sits outside this block and supplies the two event strobes.

Top module: `pwm_cmp_bank`

## Requirements
- R1: After reset, every shadow copy and every active copy reads zero.
- R2: A write with wr_addr[2]=0 stores wr_data in the shadow copy of register wr_addr[1:0], where 0=A, 1=B, 2=C and 3=D. It does not change the active copy until a selected load event occurs.
- R3: load_sel holds two bits per register, at bits [2i+1:2i] for register i. The code 00 selects load on ctr_zero, 01 selects load on ctr_prd, and 10 or 11 selects load on either strobe. A strobe that is not selected causes no transfer.
- R4: Every selected event that finds a pending shadow value transfers it. Back-to-back write and event pairs each update the active copy, and no event is skipped.
- R5: A selected event transfers only if the shadow copy was written since the last transfer. Otherwise the active copy keeps its value, even if it differs from the shadow copy.
- R6: If a shadow write and a selected event for the same register happen in the same cycle, the active copy takes the newly written value at that clock edge.
- R7: While direct_mode[i]=0 (shadow mode, the reset default), a write with wr_addr[2]=1 to register i leaves its active copy unchanged.
- R8: While direct_mode[i]=1, a write with wr_addr[2]=1 to register i updates its active copy at that clock edge, and load events do not transfer into it.
- R9: rd_data returns, without delay, the shadow copy (rd_addr[2]=0) or the active copy (rd_addr[2]=1) of register rd_addr[1:0].
- R10: cmp_active carries the active copy of register i at bits [16i+15:16i]. Each register's state changes only through its own addresses, controls and selected events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Bit 2 selects the copy (0 shadow, 1 active); bits 1:0 select the register |
| wr_data | input | 16 | Write value |
| rd_addr | input | 3 | Readback address, encoded like wr_addr |
| rd_data | output | 16 | Readback value |
| direct_mode | input | 4 | Per register: 1 disables double-buffering |
| load_sel | input | 8 | Per-register load event select, two bits each |
| ctr_zero | input | 1 | Counter-equals-zero strobe |
| ctr_prd | input | 1 | Counter-equals-period strobe |
| cmp_active | output | 64 | The four active compare values, A in the low 16 bits |

## Verification
A wrong pending flag is visible at the ports only at the next selected event. At that edge the active value either moves when it should hold, or holds when it should move. The bench therefore places events both with and without a preceding shadow write. A wrong shadow or active copy shows on rd_data in the first cycle after the write that caused it. The reference model compares both outputs after every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
  parameter int DW   = 16,
  parameter int NREG = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [$clog2(NREG):0] wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [$clog2(NREG):0] rd_addr,
  output logic [DW-1:0]        rd_data,
  input  logic [NREG-1:0]      direct_mode,
  input  logic [2*NREG-1:0]    load_sel,
  input  logic                 ctr_zero,
  input  logic                 ctr_prd,
  output logic [NREG*DW-1:0]   cmp_active
);
  localparam int IW = $clog2(NREG);
  localparam int AW = IW + 1;

  logic [NREG-1:0][DW-1:0] shd, act;
  logic [NREG-1:0]         pend, wsh, wac, ev, xfer;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      wsh[i] = wr_en && !wr_addr[AW-1] && (wr_addr[IW-1:0] == IW'(i));
      wac[i] = wr_en &&  wr_addr[AW-1] && (wr_addr[IW-1:0] == IW'(i));
      case (load_sel[2*i +: 2])
        2'b00:   ev[i] = ctr_zero;
        2'b01:   ev[i] = ctr_prd;
        default: ev[i] = ctr_zero | ctr_prd;
      endcase
      xfer[i] = !direct_mode[i] && ev[i] && (pend[i] || wsh[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd  <= '0;
      act  <= '0;
      pend <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wsh[i]) shd[i] <= wr_data;
        if (xfer[i])
          act[i] <= wsh[i] ? wr_data : shd[i];
        else if (wac[i] && direct_mode[i])
          act[i] <= wr_data;
        if (xfer[i])      pend[i] <= 1'b0;
        else if (wsh[i])  pend[i] <= 1'b1;
      end
    end
  end

  assign rd_data    = rd_addr[AW-1] ? act[rd_addr[IW-1:0]] : shd[rd_addr[IW-1:0]];
  assign cmp_active = act;
endmodule

module pwm_cmp_bank_chk #(
  parameter int DW   = 16,
  parameter int NREG = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [$clog2(NREG):0] wr_addr,
  input logic [DW-1:0]         wr_data,
  input logic [$clog2(NREG):0] rd_addr,
  input logic [DW-1:0]         rd_data,
  input logic [NREG-1:0]       direct_mode,
  input logic [2*NREG-1:0]     load_sel,
  input logic                  ctr_zero,
  input logic                  ctr_prd,
  input logic [NREG*DW-1:0]    cmp_active
);
  localparam int IW = $clog2(NREG);
  localparam int AW = IW + 1;

  AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctr_zero && !ctr_prd && !(wr_en && wr_addr[AW-1])) |=> $stable(cmp_active)); // R5

  AST_SHADOW_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[AW-1]) |=> ((rd_addr != $past(wr_addr)) || (rd_data == $past(wr_data)))); // R9

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic sel_ev;
    assign sel_ev = (load_sel[2*i +: 2] == 2'b00) ? ctr_zero :
                    (load_sel[2*i +: 2] == 2'b01) ? ctr_prd : (ctr_zero | ctr_prd);

    AST_ACTIVE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == {1'b1, IW'(i)} && !direct_mode[i] && !ctr_zero && !ctr_prd)
      |=> $stable(cmp_active[i*DW +: DW])); // R7

    AST_DIRECT_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == {1'b1, IW'(i)} && direct_mode[i])
      |=> (cmp_active[i*DW +: DW] == $past(wr_data))); // R8

    AST_SAME_CYCLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == {1'b0, IW'(i)} && !direct_mode[i] && sel_ev)
      |=> (cmp_active[i*DW +: DW] == $past(wr_data))); // R6
  end
endmodule

bind pwm_cmp_bank pwm_cmp_bank_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .direct_mode(direct_mode), .load_sel(load_sel),
  .ctr_zero(ctr_zero), .ctr_prd(ctr_prd), .cmp_active(cmp_active)
);

// File: tb/pwm_cmp_bank_tb.sv
module pwm_cmp_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  direct_mode = '0;
  logic [7:0]  load_sel = '0;
  logic        ctr_zero = 1'b0;
  logic        ctr_prd = 1'b0;
  logic [63:0] cmp_active;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_shd [4];
  logic [15:0] m_act [4];
  bit          m_pend [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_cmp_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .direct_mode(direct_mode), .load_sel(load_sel),
    .ctr_zero(ctr_zero), .ctr_prd(ctr_prd), .cmp_active(cmp_active)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 4; i++) begin
      bit wsh, wac, ev, tr;
      wsh = wr_en && wr_addr == {1'b0, 2'(i)};
      wac = wr_en && wr_addr == {1'b1, 2'(i)};
      case (load_sel[2*i +: 2])
        2'b00:   ev = ctr_zero;
        2'b01:   ev = ctr_prd;
        default: ev = ctr_zero || ctr_prd;
      endcase
      tr = !direct_mode[i] && ev && (m_pend[i] || wsh);
      if (tr) m_act[i] = wsh ? wr_data : m_shd[i];
      else if (direct_mode[i] && wac) m_act[i] = wr_data;
      if (wsh) m_shd[i] = wr_data;
      if (tr) m_pend[i] = 0;
      else if (wsh) m_pend[i] = 1;
    end
  endtask

  task automatic compare(string tag);
    for (int i = 0; i < 4; i++) chk({tag, " cmp_active"}, cmp_active[i*16 +: 16], m_act[i]);
    chk({tag, " rd_data"}, rd_data, rd_addr[2] ? m_act[rd_addr[1:0]] : m_shd[rd_addr[1:0]]);
  endtask

  task automatic cyc(string tag, bit we, logic [2:0] a, logic [15:0] d, bit z, bit p, logic [2:0] ra);
    wr_en = we; wr_addr = a; wr_data = d; ctr_zero = z; ctr_prd = p; rd_addr = ra;
    @(posedge clk);
    model_step();
    #1;
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_shd[i] = '0; m_act[i] = '0; m_pend[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    chk("R1 active", cmp_active[15:0], 16'h0);
    for (int a = 0; a < 8; a++) cyc("R1", 0, 0, 0, 0, 0, 3'(a));

    // R2: shadow write, active held
    cyc("R2", 1, 3'b000, 16'h1111, 0, 0, 3'b000);
    chk("R2 shadow rb", rd_data, 16'h1111);
    chk("R2 active held", cmp_active[15:0], 16'h0);
    // R3: period strobe ignored under load-on-zero
    cyc("R3", 0, 0, 0, 0, 1, 3'b100);
    chk("R3 prd ignored", rd_data, 16'h0);
    cyc("R3", 0, 0, 0, 1, 0, 3'b100);
    chk("R3 zero loads", rd_data, 16'h1111);
    // R5: no pending write, no transfer
    cyc("R5", 1, 3'b100, 16'hAAAA, 0, 0, 3'b100);
    chk("R7 active wr ignored", rd_data, 16'h1111);
    direct_mode = 4'b0001;
    cyc("R8", 1, 3'b100, 16'h2222, 0, 0, 3'b100);
    chk("R8 direct wr", rd_data, 16'h2222);
    cyc("R8", 0, 0, 0, 1, 1, 3'b100);
    chk("R8 no event load", rd_data, 16'h2222);
    direct_mode = 4'b0000;
    cyc("R5", 0, 0, 0, 1, 1, 3'b100);
    chk("R5 hold without pending", rd_data, 16'h2222);

    // R3: B loads on period only
    load_sel = 8'b00_00_01_00;
    cyc("R3", 1, 3'b001, 16'h3333, 1, 0, 3'b101);
    chk("R3 B zero ignored", rd_data, 16'h0);
    cyc("R3", 0, 0, 0, 0, 1, 3'b101);
    chk("R3 B prd loads", rd_data, 16'h3333);
    // R3: C loads on either (10), D on either (11)
    load_sel = 8'b11_10_01_00;
    cyc("R3", 1, 3'b010, 16'h4444, 0, 1, 3'b110);
    chk("R3 C either prd", rd_data, 16'h4444);
    cyc("R3", 1, 3'b011, 16'h5555, 1, 0, 3'b111);
    chk("R3 D either zero", rd_data, 16'h5555);
    chk("R10 A untouched", cmp_active[15:0], 16'h2222);

    // R6: same-cycle write and event
    cyc("R6", 1, 3'b000, 16'h6666, 1, 0, 3'b100);
    chk("R6 new value", rd_data, 16'h6666);

    // R4: every event transfers
    for (int k = 0; k < 4; k++) begin
      cyc("R4", 1, 3'b000, 16'(16'h7000 + k), 0, 0, 3'b100);
      cyc("R4", 0, 0, 0, 1, 0, 3'b100);
      chk("R4 each event", rd_data, 16'(16'h7000 + k));
    end

    // R9/R10: randomized traffic against the model
    for (int n = 0; n < 4000; n++) begin
      if (n % 97 == 0) begin
        direct_mode = 4'($urandom);
        load_sel = 8'($urandom);
      end
      cyc("R9 model", ($urandom % 3) != 0, 3'($urandom), 16'($urandom),
          ($urandom % 5) == 0, ($urandom % 5) == 0, 3'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule